// File: doc/BRIEF.md
# DMA Status Read-Back Sequencer

This block answers processor reads from the DMA controller's port. Every completed read strobe returns one byte taken from a set of internal values: a status byte, the two halves of the 16-bit transfer counter, and the two halves of each of the two current port addresses. A 7-bit selection mask, loaded by the command decoder, decides which of those seven bytes take part. Successive reads walk through the selected bytes from the lowest mask bit upward and then start again at the lowest one.

The command decoder also sends three strobes. One moves the walk back to its start. One makes the next read return the status byte. One clears the two sticky status flags. The transfer engine sends an end-of-block pulse, an at-least-one-byte pulse, and the live counter and address values. The read data output is combinational from the block's state and these live values, so a read always returns current figures.

Top module: `dma_readback_seq`

## Requirements
- R1: After reset the mask is 0x7F, both sticky flags are clear and the walk points at the status byte, so the first read returns 0x3A.
- R2: The status byte is 00E1101T: bits 7 and 6 are 0, bits 4, 3 and 1 are 1, and bit 2 is 0. Bit 5 (E) is 0 once end-of-block has been flagged and 1 otherwise. Bit 0 (T) is 1 once at least one byte has been flagged.
- R3: Mask bit k selects a source: 0 status, 1 counter[7:0], 2 counter[15:8], 3 port A address[7:0], 4 port A address[15:8], 5 port B address[7:0], 6 port B address[15:8].
- R4: Each read strobe moves the walk to the next enabled mask bit above the current one. After the highest enabled bit it goes back to the lowest enabled bit.
- R5: The initialise-sequence strobe moves the walk to the lowest enabled mask bit and cancels a pending status request.
- R6: After the read-status strobe, the next read returns the status byte. That read leaves the walk position unchanged.
- R7: A mask load stores the new mask and moves the walk to the lowest enabled bit of that mask.
- R8: While the mask is 0, every read returns the status byte.
- R9: The reinitialise-status strobe clears both sticky flags. A flag pulse arriving in the same cycle still sets its flag.
- R10: Without a read strobe, an initialise strobe or a mask load, the walk position does not change. Flag pulses, the other strobes and changing engine values do not move it.
- R11: The flags are sticky: one pulse sets a flag, and it stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_wr_i | input | 1 | Load the selection mask |
| mask_data_i | input | 7 | New selection mask |
| cmd_init_seq_i | input | 1 | Restart the read walk |
| cmd_rd_status_i | input | 1 | Next read returns status |
| cmd_reinit_i | input | 1 | Clear the sticky status flags |
| eob_i | input | 1 | End-of-block pulse from the engine |
| any_i | input | 1 | Byte-transferred pulse from the engine |
| count_i | input | 16 | Live transfer counter |
| addr_a_i | input | 16 | Live port A address |
| addr_b_i | input | 16 | Live port B address |
| rd_i | input | 1 | Completed processor read strobe |
| rd_data_o | output | 8 | Byte returned to the current read |

## Verification
The assertions assume that each strobe lasts one cycle. They also assume that the mask load and the initialise strobe never share a cycle with a read strobe. The priority between those strobes is defined in the RTL, but the properties about walk movement assume no overlap. The stimulus raises one command per task call and separates each read with a low cycle, so it keeps within these assumptions. The bench model compares the output on every cycle, including the idle cycles between commands, and therefore also covers the cycles that the assertions do not constrain.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int RB_SEL_N = 7;
  localparam int RB_PTR_W = 3;
  localparam int RB_DW    = 8;

  typedef logic [RB_SEL_N-1:0] rb_mask_t;
  typedef logic [RB_PTR_W-1:0] rb_ptr_t;

  localparam rb_mask_t RB_MASK_RST = '1;

  // status byte: 0 0 ~eob 1 1 0 1 any
  function automatic logic [RB_DW-1:0] rb_status_byte(input logic eob_seen, input logic any_seen);
    return {2'b00, ~eob_seen, 4'b1101, any_seen};
  endfunction

  function automatic rb_ptr_t rb_first(input rb_mask_t mask);
    rb_ptr_t res;
    logic    found;
    res   = '0;
    found = 1'b0;
    for (int k = 0; k < RB_SEL_N; k++) begin
      if (!found && mask[k]) begin
        res   = RB_PTR_W'(k);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic rb_ptr_t rb_next(input rb_mask_t mask, input rb_ptr_t cur);
    rb_ptr_t res;
    logic    found;
    int      idx;
    res   = cur;
    found = 1'b0;
    for (int k = 1; k <= RB_SEL_N; k++) begin
      idx = (int'(cur) + k) % RB_SEL_N;
      if (!found && mask[idx]) begin
        res   = RB_PTR_W'(idx);
        found = 1'b1;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/rb_flags.sv
module rb_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic eob_i,
  input  logic any_i,
  input  logic clear_i,
  output logic eob_seen_o,
  output logic any_seen_o
);
  logic eob_q, any_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eob_q <= 1'b0;
      any_q <= 1'b0;
    end else begin
      eob_q <= eob_i | (eob_q & ~clear_i);
      any_q <= any_i | (any_q & ~clear_i);
    end
  end

  assign eob_seen_o = eob_q;
  assign any_seen_o = any_q;

  // R9: a clear with no new pulse leaves the flags low
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i && !eob_i && !any_i |=> !eob_q && !any_q);
  // R11: flags are sticky without a clear
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    eob_q && !clear_i |=> eob_q);
endmodule

// File: rtl/rb_sequencer.sv
module rb_sequencer
  import dma_rb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mask_wr_i,
  input  rb_mask_t mask_data_i,
  input  logic     init_i,
  input  logic     rd_status_i,
  input  logic     rd_i,
  output rb_mask_t mask_o,
  output rb_ptr_t  ptr_o,
  output logic     force_status_o
);
  rb_mask_t mask_q;
  rb_ptr_t  ptr_q;
  logic     force_q;
  logic     step_ev;     // read that moves the walk
  logic     restart_ev;  // walk goes back to the first enabled entry

  assign restart_ev = mask_wr_i | init_i;
  assign step_ev    = rd_i & ~restart_ev & ~force_q & (mask_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= RB_MASK_RST;
      ptr_q   <= '0;
      force_q <= 1'b0;
    end else begin
      if (mask_wr_i) begin
        mask_q <= mask_data_i;
        ptr_q  <= rb_first(mask_data_i);
      end else if (init_i) begin
        ptr_q  <= rb_first(mask_q);
      end else if (step_ev) begin
        ptr_q  <= rb_next(mask_q, ptr_q);
      end
      if (rd_status_i)
        force_q <= 1'b1;
      else if (rd_i || restart_ev)
        force_q <= 1'b0;
    end
  end

  assign mask_o         = mask_q;
  assign ptr_o          = ptr_q;
  assign force_status_o = force_q;

  // R3: walk index always names one of the seven sources
  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < RB_SEL_N);
  // R4: with a non-empty mask the walk sits on an enabled entry
  a_r4_ptr_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != '0) |-> mask_q[ptr_q]);
  // R10: no read, init or mask load keeps the walk still
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i && !init_i && !mask_wr_i |=> $stable(ptr_q));
  // R6: read-status request is pending on the next cycle
  a_r6_force_set: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status_i |=> force_q);
  // R6: a forced read does not move the walk
  a_r6_force_hold: assert property (@(posedge clk) disable iff (!rst_n)
    force_q && rd_i && !init_i && !mask_wr_i |=> $stable(ptr_q));
  // R5: init cancels a pending status request
  a_r5_init_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    init_i && !rd_status_i |=> !force_q);
endmodule

// File: rtl/rb_mux.sv
module rb_mux
  import dma_rb_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic              sel_status_i,
  input  rb_ptr_t           ptr_i,
  input  logic [RB_DW-1:0]  status_i,
  input  logic [FIELD_W-1:0] count_i,
  input  logic [FIELD_W-1:0] addr_a_i,
  input  logic [FIELD_W-1:0] addr_b_i,
  output logic [RB_DW-1:0]  data_o
);
  localparam int HALVES  = FIELD_W / RB_DW;
  localparam int NFIELDS = 3;

  logic [RB_DW-1:0]  src [RB_SEL_N];
  logic [FIELD_W-1:0] fields [NFIELDS];

  assign fields[0] = count_i;
  assign fields[1] = addr_a_i;
  assign fields[2] = addr_b_i;
  assign src[0]    = status_i;

  for (genvar f = 0; f < NFIELDS; f++) begin : g_field
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign src[1 + f*HALVES + h] = fields[f][h*RB_DW +: RB_DW];
    end
  end

  always_comb begin
    data_o = src[0];
    if (!sel_status_i) begin
      for (int k = 0; k < RB_SEL_N; k++)
        if (ptr_i == RB_PTR_W'(k)) data_o = src[k];
    end
  end
endmodule

// File: rtl/dma_readback_seq.sv
module dma_readback_seq
  import dma_rb_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_wr_i,
  input  logic [6:0]         mask_data_i,
  input  logic               cmd_init_seq_i,
  input  logic               cmd_rd_status_i,
  input  logic               cmd_reinit_i,
  input  logic               eob_i,
  input  logic               any_i,
  input  logic [FIELD_W-1:0] count_i,
  input  logic [FIELD_W-1:0] addr_a_i,
  input  logic [FIELD_W-1:0] addr_b_i,
  input  logic               rd_i,
  output logic [7:0]         rd_data_o
);
  logic             eob_seen, any_seen;
  rb_mask_t         mask;
  rb_ptr_t          ptr;
  logic             force_status;
  logic             sel_status;
  logic [RB_DW-1:0] status_byte;

  rb_flags u_flags (
    .clk(clk), .rst_n(rst_n), .eob_i(eob_i), .any_i(any_i),
    .clear_i(cmd_reinit_i), .eob_seen_o(eob_seen), .any_seen_o(any_seen)
  );

  rb_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i),
    .init_i(cmd_init_seq_i), .rd_status_i(cmd_rd_status_i), .rd_i(rd_i),
    .mask_o(mask), .ptr_o(ptr), .force_status_o(force_status)
  );

  assign status_byte = rb_status_byte(eob_seen, any_seen);
  assign sel_status  = force_status | (mask == '0);

  rb_mux #(.FIELD_W(FIELD_W)) u_mux (
    .sel_status_i(sel_status), .ptr_i(ptr), .status_i(status_byte),
    .count_i(count_i), .addr_a_i(addr_a_i), .addr_b_i(addr_b_i), .data_o(rd_data_o)
  );

  // R2: fixed bits of the status byte whenever status is returned
  a_r2_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_status || ptr == '0) |-> (rd_data_o[7:6] == 2'b00 && rd_data_o[4:1] == 4'b1101));
  // R8: empty mask returns status with fixed bits
  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (rd_data_o[4:1] == 4'b1101));
endmodule

// File: tb/dma_readback_seq_tb.sv
`timescale 1ns/1ps
module dma_readback_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mask_wr = 0, init = 0, rdst = 0, reinit = 0, eob = 0, anyb = 0, rd = 0;
  logic [6:0] mdata = '0;
  logic [15:0] cnt = 16'h1234, aa = 16'hA55A, bb = 16'h0FF0;
  logic [7:0] dout;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_readback_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mask_wr_i(mask_wr), .mask_data_i(mdata),
    .cmd_init_seq_i(init), .cmd_rd_status_i(rdst), .cmd_reinit_i(reinit),
    .eob_i(eob), .any_i(anyb), .count_i(cnt), .addr_a_i(aa), .addr_b_i(bb),
    .rd_i(rd), .rd_data_o(dout)
  );

  // behavioural reference model
  int m_mask, m_pos, m_force, m_eob, m_any;

  function automatic int m_status();
    return 8'h1A | ((m_eob != 0) ? 0 : 8'h20) | ((m_any != 0) ? 1 : 0);
  endfunction

  function automatic int m_value();
    if (m_force != 0 || m_mask == 0) return m_status();
    case (m_pos)
      0: return m_status();
      1: return cnt % 256;
      2: return cnt / 256;
      3: return aa % 256;
      4: return aa / 256;
      5: return bb % 256;
      default: return bb / 256;
    endcase
  endfunction

  function automatic int lowest(int m);
    for (int i = 0; i < 7; i++) if (((m >> i) & 1) != 0) return i;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 127; m_pos = 0; m_force = 0; m_eob = 0; m_any = 0;
    end else begin
      int np; int nf;
      np = m_pos; nf = m_force;
      if (mask_wr) begin m_mask = mdata; np = lowest(mdata); end
      else if (init) np = lowest(m_mask);
      else if (rd && m_force == 0 && m_mask != 0) begin
        for (int s = 1; s <= 7; s++) begin
          int c; c = (m_pos + s) % 7;
          if (np == m_pos && ((m_mask >> c) & 1) != 0) np = c;
        end
      end
      if (rdst) nf = 1; else if (rd || init || mask_wr) nf = 0;
      m_pos = np; m_force = nf;
      if (reinit) begin m_eob = 0; m_any = 0; end
      if (eob) m_eob = 1;
      if (anyb) m_any = 1;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) chk("MODEL", dout, m_value());
  end

  task automatic do_read(string tag, int exp);
    @(negedge clk); #1;
    chk(tag, dout, exp);
    rd = 1;
    @(negedge clk); rd = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic load_mask(int m);
    @(negedge clk); mdata = 7'(m); mask_wr = 1;
    @(negedge clk); mask_wr = 0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R3 source order, R4 wrap
    do_read("R1", 8'h3A);
    do_read("R3 cnt lo", 8'h34);
    do_read("R3 cnt hi", 8'h12);
    do_read("R3 A lo", 8'h5A);
    do_read("R3 A hi", 8'hA5);
    do_read("R3 B lo", 8'hF0);
    do_read("R3 B hi", 8'h0F);
    do_read("R4 wrap", 8'h3A);
    // R11 sticky flags, R2 status format
    pulse(anyb);
    repeat (2) @(negedge clk);
    pulse(init);
    do_read("R11 any sticky", 8'h3B);
    pulse(eob);
    pulse(init);
    do_read("R2 eob inverted", 8'h1B);
    // R7 mask load
    load_mask(7'h12);
    do_read("R7 first enabled", 8'h34);
    do_read("R4 next enabled", 8'hA5);
    do_read("R4 wrap sparse", 8'h34);
    // R6 read-status
    pulse(rdst);
    do_read("R6 forced status", 8'h1B);
    do_read("R6 walk kept", 8'hA5);
    // R10 nothing moves the walk without a read
    pulse(eob); pulse(anyb); pulse(reinit); pulse(anyb); pulse(eob);
    @(negedge clk); cnt = 16'h5678;
    repeat (3) @(negedge clk);
    do_read("R10 walk still", 8'h78);
    // R9 reinit clears, concurrent pulse still sets
    pulse(reinit);
    pulse(rdst);
    do_read("R9 cleared", 8'h3A);
    @(negedge clk); reinit = 1; eob = 1;
    @(negedge clk); reinit = 0; eob = 0;
    pulse(rdst);
    do_read("R9 same cycle set", 8'h1A);
    // R8 empty mask
    load_mask(0);
    do_read("R8 empty a", 8'h1A);
    do_read("R8 empty b", 8'h1A);
    // R5 init cancels forced status
    load_mask(7'h06);
    pulse(rdst);
    pulse(init);
    do_read("R5 init cancels", 8'h78);
    do_read("R5 then next", 8'h56);
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule